// File: doc/BRIEF.md
# Flash Read Response Selector

This block builds the data word returned on every read of a parallel NOR flash model. The command sequencer, which lives elsewhere, tells it which mode the device is in. From that mode the block picks one of four sources: the array word, the device identification words, the program/erase status byte, or an entry of a query table that is built into the block. Array storage, command decoding and erase timing stay outside. The array word for the current address must be present on `arr_data` in the same cycle as the read strobe.

The block owns one piece of state besides the output register. This is the toggle bit that flips bit 6 of the status byte after every status read. Software polls that bit to see whether an operation is still running. The query table's geometry entries come from the sector size and the sector count, which are set when the design is elaborated. Byte addresses are turned into word offsets by the bus width. Narrower values are zero-extended to the bus width.

Top module: `nfl_read_resp`

## Requirements
- R1: After a synchronous active-low reset, `rd_valid` is 0, `rd_data` is 0 and the status toggle is clear, so the first status read returns the status byte unchanged.
- R2: A read strobe sampled on a rising edge gives `rd_valid`=1 and the selected word on `rd_data` after that same edge. With no strobe, `rd_valid` is 0 and `rd_data` keeps its value.
- R3: For mode codes 0 (read), 1 (erase setup) and the unused codes 5, 6 and 7, the read returns `arr_data` unchanged.
- R4: In mode code 2 (identify), word offset 0 returns `id_w0`, word offset 1 returns `id_w1`, and word offset 2 returns 0x00, which means no sector is protected.
- R5: In identify mode, word offsets 0x0E and 0x0F return `id_w2` and `id_w3`. If that word equals 0x00FF, the read returns `arr_data` instead. Every other word offset also returns `arr_data`.
- R6: In mode code 3 (status), the read returns `stat_in` with bit 6 XORed with the toggle bit. The toggle inverts after each status read and after nothing else.
- R7: The word offset is byte address bits 7:0 shifted right by 0, 1 or 2 for a bus of 1, 2 or 4 bytes. In mode code 4 (query), word offsets 0x52 and above read 0.
- R8: The query identity entries are 0x51, 0x52, 0x59 at 0x10 to 0x12, command set 0x02/0x00 at 0x13/0x14, and extended-table pointer 0x31/0x00 at 0x15/0x16.
- R9: The interface and timing entries are 0x27 and 0x36 at 0x1B/0x1C, 0x07 at 0x1F, and 0x09, 0x0C, 0x01 at 0x21 to 0x23. Also 0x0A and 0x0D at 0x25/0x26, and 0x02 at 0x28.
- R10: The geometry entries are as follows. 0x27 holds log2 of (SECTOR_BYTES × NUM_SECTORS), both powers of two. 0x2C holds 0x01. 0x2D/0x2E hold NUM_SECTORS−1 as low and high byte. 0x2F/0x30 hold SECTOR_BYTES/256 as low and high byte.
- R11: The extended table holds 0x50, 0x52, 0x49, 0x31, 0x30 at 0x31 to 0x35. Every query offset below 0x52 that is not listed in R8 to R11 reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_stb | input | 1 | Read strobe, one cycle per read |
| rd_addr | input | ADDR_W | Byte offset within the device |
| mode_i | input | 3 | Current mode code from the sequencer |
| arr_data | input | DATA_W | Array word at `rd_addr` |
| stat_in | input | 8 | Status byte from the sequencer |
| id_w0 | input | 16 | Identification word 0 |
| id_w1 | input | 16 | Identification word 1 |
| id_w2 | input | 16 | Optional identification word 2 (0x00FF = absent) |
| id_w3 | input | 16 | Optional identification word 3 (0x00FF = absent) |
| rd_valid | output | 1 | Read response valid |
| rd_data | output | DATA_W | Read response word |

## Verification
On every cycle, the assertions check the following:
- the strobe-to-valid timing;
- that the output holds between reads;
- that the toggle flips exactly on status reads and stays put otherwise;
- that the top status bit passes through;
- the zero entries for identify offset 2 and for out-of-range query offsets.

Some behaviour only the bench scenarios can show, because it needs an independent reference. This covers the exact query table contents and the values computed from geometry. It also covers the fallback to array data when an optional identification word is absent. Finally, it covers the alternating bit-6 sequence seen across runs of status reads that are mixed with other reads.

// File: rtl/nfl_resp_pkg.sv
// Package: shared mode codes and constants for the flash read response selector.
// Assumes the sequencer drives the 3-bit mode codes listed here.
package nfl_resp_pkg;

    typedef enum logic [2:0] {
        MODE_READ    = 3'd0,
        MODE_ERSETUP = 3'd1,
        MODE_IDENT   = 3'd2,
        MODE_STATUS  = 3'd3,
        MODE_QUERY   = 3'd4
    } resp_mode_e;

    localparam logic [7:0]  QRY_LEN   = 8'h52;
    localparam logic [15:0] ID_ABSENT = 16'h00FF;

    // Right shift that turns a byte offset into a word offset.
    function automatic int unsigned word_shift(input int unsigned bus_bytes);
        if (bus_bytes == 4) return 2;
        else if (bus_bytes == 2) return 1;
        else return 0;
    endfunction

endpackage

// File: rtl/nfl_cfi_table.sv
// Module: combinational query-table lookup.
// Geometry entries are derived from the parameters at elaboration.
// Assumes SECTOR_BYTES and NUM_SECTORS are powers of two.
module nfl_cfi_table #(
    parameter int unsigned SECTOR_BYTES = 4096,
    parameter int unsigned NUM_SECTORS  = 16
) (
    input  logic [7:0] idx,
    output logic [7:0] entry
);
    localparam int unsigned CHIP_LOG2 = $clog2(SECTOR_BYTES * NUM_SECTORS);
    localparam logic [15:0] BLK_M1    = 16'(NUM_SECTORS - 1);
    localparam logic [15:0] SEC_UNITS = 16'(SECTOR_BYTES / 256);

    // Table decode; anything not listed (including offsets past the end) is zero.
    always_comb begin
        case (idx)
            8'h10: entry = 8'h51;
            8'h11: entry = 8'h52;
            8'h12: entry = 8'h59;
            8'h13: entry = 8'h02;
            8'h15: entry = 8'h31;
            8'h1B: entry = 8'h27;
            8'h1C: entry = 8'h36;
            8'h1F: entry = 8'h07;
            8'h21: entry = 8'h09;
            8'h22: entry = 8'h0C;
            8'h23: entry = 8'h01;
            8'h25: entry = 8'h0A;
            8'h26: entry = 8'h0D;
            8'h27: entry = 8'(CHIP_LOG2);
            8'h28: entry = 8'h02;
            8'h2C: entry = 8'h01;
            8'h2D: entry = BLK_M1[7:0];
            8'h2E: entry = BLK_M1[15:8];
            8'h2F: entry = SEC_UNITS[7:0];
            8'h30: entry = SEC_UNITS[15:8];
            8'h31: entry = 8'h50;
            8'h32: entry = 8'h52;
            8'h33: entry = 8'h49;
            8'h34: entry = 8'h31;
            8'h35: entry = 8'h30;
            default: entry = 8'h00;
        endcase
    end

endmodule

// File: rtl/nfl_ident_sel.sv
// Module: identify-mode decode.
// Gives the ID value and a hit flag; without a hit the caller falls back to array data.
// Optional words equal to 0x00FF count as absent.
module nfl_ident_sel
    import nfl_resp_pkg::*;
(
    input  logic [7:0]  woff,
    input  logic [15:0] id_w0,
    input  logic [15:0] id_w1,
    input  logic [15:0] id_w2,
    input  logic [15:0] id_w3,
    output logic        id_hit,
    output logic [15:0] id_val
);
    // Offset decode with fallthrough for absent optional words.
    always_comb begin
        id_hit = 1'b0;
        id_val = 16'h0000;
        case (woff)
            8'h00: begin id_hit = 1'b1; id_val = id_w0; end
            8'h01: begin id_hit = 1'b1; id_val = id_w1; end
            8'h02: begin id_hit = 1'b1; id_val = 16'h0000; end
            8'h0E: begin id_hit = (id_w2 != ID_ABSENT); id_val = id_w2; end
            8'h0F: begin id_hit = (id_w3 != ID_ABSENT); id_val = id_w3; end
            default: begin id_hit = 1'b0; id_val = 16'h0000; end
        endcase
    end

endmodule

// File: rtl/nfl_status_tgl.sv
// Module: holds the status toggle bit. It inverts after every status read.
// Assumes stat_rd is high for exactly one cycle per status read.
module nfl_status_tgl (
    input  logic clk,
    input  logic rst_n,
    input  logic stat_rd,
    output logic tgl
);
    // Toggle register: flips on each status read, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) tgl <= 1'b0;
        else if (stat_rd) tgl <= ~tgl;
    end

    p_tgl_flips_r6: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd |=> (tgl != $past(tgl)));
    p_tgl_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_rd |=> $stable(tgl));

endmodule

// File: rtl/nfl_read_resp.sv
// Module: read response selector for a parallel NOR flash model.
// It steers array data, ID words, the toggling status byte or query-table entries
// by the mode code, and registers the result one cycle after the strobe.
// Assumes arr_data matches rd_addr in the strobe cycle and ADDR_W >= 8.
module nfl_read_resp
    import nfl_resp_pkg::*;
#(
    parameter int unsigned BUS_BYTES    = 2,
    parameter int unsigned SECTOR_BYTES = 4096,
    parameter int unsigned NUM_SECTORS  = 16,
    localparam int unsigned DATA_W = 8 * BUS_BYTES,
    localparam int unsigned ADDR_W = $clog2(SECTOR_BYTES * NUM_SECTORS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_stb,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [2:0]        mode_i,
    input  logic [DATA_W-1:0] arr_data,
    input  logic [7:0]        stat_in,
    input  logic [15:0]       id_w0,
    input  logic [15:0]       id_w1,
    input  logic [15:0]       id_w2,
    input  logic [15:0]       id_w3,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    localparam int unsigned SHIFT = word_shift(BUS_BYTES);

    logic [7:0]  woff;
    logic [7:0]  qry_entry;
    logic        id_hit;
    logic [15:0] id_val;
    logic        tgl;
    logic        stat_rd;
    logic [31:0] sel32;

    // Word offset within the low address byte.
    assign woff    = rd_addr[7:0] >> SHIFT;
    assign stat_rd = rd_stb && (mode_i == MODE_STATUS);

    nfl_cfi_table #(
        .SECTOR_BYTES (SECTOR_BYTES),
        .NUM_SECTORS  (NUM_SECTORS)
    ) u_qry (
        .idx   (woff),
        .entry (qry_entry)
    );

    nfl_ident_sel u_ident (
        .woff   (woff),
        .id_w0  (id_w0),
        .id_w1  (id_w1),
        .id_w2  (id_w2),
        .id_w3  (id_w3),
        .id_hit (id_hit),
        .id_val (id_val)
    );

    nfl_status_tgl u_tgl (
        .clk     (clk),
        .rst_n   (rst_n),
        .stat_rd (stat_rd),
        .tgl     (tgl)
    );

    // Source select by mode; unknown codes behave as plain reads.
    always_comb begin
        case (mode_i)
            MODE_IDENT:  sel32 = id_hit ? 32'(id_val) : 32'(arr_data);
            MODE_STATUS: sel32 = 32'({stat_in[7], stat_in[6] ^ tgl, stat_in[5:0]});
            MODE_QUERY:  sel32 = (woff < QRY_LEN) ? 32'(qry_entry) : 32'h0;
            default:     sel32 = 32'(arr_data);
        endcase
    end

    // Response register: captures on strobe, holds otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_stb;
            if (rd_stb) rd_data <= sel32[DATA_W-1:0];
        end
    end

    p_valid_on_stb_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> rd_valid);
    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> (!rd_valid && $stable(rd_data)));
    p_status_top_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd |=> (rd_data[7] == $past(stat_in[7])));
    p_ident_unprot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && mode_i == MODE_IDENT && woff == 8'h02) |=> (rd_data == '0));
    p_query_beyond_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && mode_i == MODE_QUERY && woff >= QRY_LEN) |=> (rd_data == '0));

endmodule

// File: tb/test_nfl_read_resp.sv
// Bench: directed corner cases plus seeded random reads, checked against bench reference functions.
module test_nfl_read_resp;
    localparam int unsigned BUS_BYTES = 2;
    localparam int unsigned SEC_B     = 4096;
    localparam int unsigned NSEC      = 16;
    localparam int unsigned DW        = 8 * BUS_BYTES;
    localparam int unsigned AW        = $clog2(SEC_B * NSEC);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rd_stb = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [2:0]    mode_i = 3'd0;
    logic [DW-1:0] arr_data = '0;
    logic [7:0]    stat_in = 8'h00;
    logic [15:0]   id_w0 = 16'h0001, id_w1 = 16'h227E, id_w2 = 16'h2210, id_w3 = 16'h2201;
    logic          rd_valid;
    logic [DW-1:0] rd_data;

    int  n_cmp = 0;
    int  n_bad = 0;
    int  cyc = 0;
    bit  done = 0;
    bit  tgl_m = 0;

    always #5ns clk = ~clk;

    nfl_read_resp #(.BUS_BYTES(BUS_BYTES), .SECTOR_BYTES(SEC_B), .NUM_SECTORS(NSEC)) i_nfl_read_resp (
        .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .rd_addr(rd_addr), .mode_i(mode_i),
        .arr_data(arr_data), .stat_in(stat_in), .id_w0(id_w0), .id_w1(id_w1),
        .id_w2(id_w2), .id_w3(id_w3), .rd_valid(rd_valid), .rd_data(rd_data));

    // Reference query table, written from R8..R11.
    function automatic logic [7:0] qry_ref(input logic [7:0] w);
        case (w)
            8'h10: return 8'h51;  8'h11: return 8'h52;  8'h12: return 8'h59;
            8'h13: return 8'h02;  8'h15: return 8'h31;  8'h1B: return 8'h27;
            8'h1C: return 8'h36;  8'h1F: return 8'h07;  8'h21: return 8'h09;
            8'h22: return 8'h0C;  8'h23: return 8'h01;  8'h25: return 8'h0A;
            8'h26: return 8'h0D;  8'h27: return 8'd16;  8'h28: return 8'h02;
            8'h2C: return 8'h01;  8'h2D: return 8'h0F;  8'h2E: return 8'h00;
            8'h2F: return 8'h10;  8'h30: return 8'h00;  8'h31: return 8'h50;
            8'h32: return 8'h52;  8'h33: return 8'h49;  8'h34: return 8'h31;
            8'h35: return 8'h30;  default: return 8'h00;
        endcase
    endfunction

    // Expected response for one read; t is the modelled toggle before the read.
    function automatic logic [DW-1:0] exp_ref(input logic [2:0] m, input logic [AW-1:0] a,
                                              input logic [DW-1:0] arr, input logic [7:0] st, input bit t);
        logic [7:0] w;
        w = a[7:0] >> 1;
        case (m)
            3'd2: begin
                if (w == 8'h00) return id_w0;
                if (w == 8'h01) return id_w1;
                if (w == 8'h02) return '0;
                if (w == 8'h0E) return (id_w2 == 16'h00FF) ? arr : id_w2;
                if (w == 8'h0F) return (id_w3 == 16'h00FF) ? arr : id_w3;
                return arr;
            end
            3'd3: return DW'(st ^ (8'(t) << 6));
            3'd4: return (w >= 8'h52) ? '0 : DW'(qry_ref(w));
            default: return arr;
        endcase
    endfunction

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One strobed read; result sampled at the following negedge.
    task automatic do_read(input string req, input logic [2:0] m, input logic [AW-1:0] a,
                           input logic [DW-1:0] arr, input logic [7:0] st);
        logic [DW-1:0] e;
        @(negedge clk);
        mode_i = m; rd_addr = a; arr_data = arr; stat_in = st; rd_stb = 1'b1;
        e = exp_ref(m, a, arr, st, tgl_m);
        if (m == 3'd3) tgl_m = ~tgl_m;
        @(negedge clk);
        rd_stb = 1'b0;
        chk({req, " valid"}, DW'(rd_valid), DW'(1));
        chk(req, rd_data, e);
    endtask

    // Idle cycle: valid low and data held (R2), inputs changed to show they have no effect.
    task automatic idle_chk();
        logic [DW-1:0] held;
        held = rd_data;
        mode_i = 3'd3; arr_data = ~arr_data; stat_in = 8'hFF;
        @(negedge clk);
        chk("R2 idle valid", DW'(rd_valid), DW'(0));
        chk("R2 idle hold", rd_data, held);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state.
        chk("R1 valid", DW'(rd_valid), DW'(0));
        chk("R1 data", rd_data, '0);
        // R1/R6: first status read after reset is unchanged.
        do_read("R1 first status", 3'd3, '0, '0, 8'hC5);
        do_read("R6 second status", 3'd3, '0, '0, 8'hC5);
        do_read("R3 read between", 3'd0, 16'h1234, 16'hBEEF, 8'h00);
        do_read("R6 third status", 3'd3, '0, '0, 8'h85);
        idle_chk();
        do_read("R6 after idle", 3'd3, '0, '0, 8'h80);
        // R3: array passthrough for modes 0,1,5,6,7.
        do_read("R3 read", 3'd0, 16'hFFFE, 16'hA55A, 8'h00);
        do_read("R3 erase setup", 3'd1, 16'h0100, 16'h1357, 8'h00);
        do_read("R3 code5", 3'd5, 16'h0042, 16'h2468, 8'h00);
        do_read("R3 code6", 3'd6, 16'h0044, 16'h0F0F, 8'h00);
        do_read("R3 code7", 3'd7, 16'h0046, 16'hF0F0, 8'h00);
        // R4/R5: identify.
        do_read("R4 id0", 3'd2, 16'h0000, 16'hDEAD, 8'h00);
        do_read("R4 id1", 3'd2, 16'h0302, 16'hDEAD, 8'h00);
        do_read("R4 unprot", 3'd2, 16'h0004, 16'hDEAD, 8'h00);
        do_read("R5 id2", 3'd2, 16'h001C, 16'hDEAD, 8'h00);
        do_read("R5 id3", 3'd2, 16'h001E, 16'hDEAD, 8'h00);
        do_read("R5 other", 3'd2, 16'h0010, 16'hCAFE, 8'h00);
        id_w2 = 16'h00FF;
        do_read("R5 id2 absent", 3'd2, 16'h001C, 16'h7777, 8'h00);
        id_w3 = 16'h00FF;
        do_read("R5 id3 absent", 3'd2, 16'h001E, 16'h6666, 8'h00);
        id_w2 = 16'h2210; id_w3 = 16'h2201;
        // R7..R11: full query sweep over all word offsets.
        for (int w = 0; w < 128; w++)
            do_read("R8 R9 R10 R11 query", 3'd4, AW'(w << 1), 16'h9999, 8'h00);
        do_read("R7 high bits ignored", 3'd4, 16'hAB20, 16'h9999, 8'h00);
        do_read("R7 beyond table", 3'd4, 16'h00A4, 16'h9999, 8'h00);
        do_read("R10 log2", 3'd4, 16'h004E, 16'h0, 8'h00);
        // Random mix.
        for (int i = 0; i < 400; i++) begin
            logic [AW-1:0] a;
            a = AW'($urandom);
            if ($urandom_range(1, 0) == 1) a[7:0] = 8'($urandom_range(40, 0) << 1);
            do_read("R3 R4 R5 R6 R7 random", 3'($urandom_range(7, 0)), a, DW'($urandom), 8'($urandom));
            if ($urandom_range(3, 0) == 0) idle_chk();
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule